// File: doc/BRIEF.md
# Serial Port Sample Rate Generator

This block takes one of three input time bases and produces two timing signals for a serial port. The first is a divided bit clock, given as a level (`clkg`) and as a one-cycle strobe (`clkg_en`) that marks the start of each divided period. The second is a frame-sync level (`fsg`) whose width and spacing are both counted in divided periods. The whole block runs on the system clock. The internal peripheral time base arrives as a one-cycle tick. The two external clock pins are synchronised with a two-flop stage, and their rising edges count as ticks.

A 16-bit control word holds the frame pulse width in its upper byte and the divide value in its lower byte. A 12-bit frame period arrives on its own port. Changes to the divide value, the width or the period are held back until the current divided period ends, so a change never cuts a clock phase short. The reserved source code stops the generator, forces its outputs low and returns its counters to zero.

Top module: `sample_rate_gen`

## Requirements
- R1: A write (`cfg_we` high at a clock edge) stores `cfg_wdata` into the control word, which reads back on `cfg_word` from the next cycle. Bits 15..8 are the width W and bits 7..0 are the divide value D.
- R2: After reset, `cfg_word` reads 0x0001 (D=1, W=0) and `clkg_en` is low.
- R3: While running, `clkg_en` pulses for one cycle at the end of every D+1 selected ticks. That pulse marks the start of a new divided period.
- R4: Within a divided period, `clkg` is high for the first floor((D+1)/2) ticks and low for the rest, so an odd length has the shorter high phase. When D=0, `clkg` equals `clkg_en`.
- R5: `fsg` is high for the first W+1 divided periods of each frame.
- R6: A new frame starts every P+1 divided periods, where P is `frm_period`.
- R7: When W is greater than or equal to P, `fsg` stays high continuously while running.
- R8: Source code 01 selects `periph_tick`, 10 selects rising edges of `rx_clk_pin` and 11 selects rising edges of `tx_clk_pin`. The pins pass through a two-flop synchroniser. Activity on unselected sources has no effect.
- R9: Source code 00 is reserved. While it is selected, `clkg`, `clkg_en` and `fsg` are low and the counters are held at zero. When another code is selected, a new divided period and a new frame start from position zero.
- R10: New D, W and P values take effect only when a divided period ends (or while stopped), never in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_word | output | 16 | Stored control word |
| clk_src | input | 2 | Time base select |
| frm_period | input | 12 | Frame period P in divided periods minus one |
| periph_tick | input | 1 | Internal peripheral tick, one cycle wide |
| rx_clk_pin | input | 1 | Receive clock pin, asynchronous |
| tx_clk_pin | input | 1 | Transmit clock pin, asynchronous |
| clkg | output | 1 | Divided clock level |
| clkg_en | output | 1 | Start-of-divided-period strobe |
| fsg | output | 1 | Frame-sync level |

## Verification
The bench builds the block with its default parameters: 8-bit divide and width fields, a 12-bit period and two synchroniser stages. During random runs, divide values stay below 6, widths below 8 and periods below 10. This keeps many full frames, both odd and even divided lengths, and the saturated width case within a few thousand cycles. Directed runs cover D=0 with back-to-back ticks, W greater than or equal to P, the reserved code, and both clock pins, with the other pin toggling as a distractor.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [1:0] {
      SRC_OFF = 2'b00,
      SRC_PER = 2'b01,
      SRC_RXP = 2'b10,
      SRC_TXP = 2'b11
   } sg_src_e;
endpackage

// File: rtl/sg_edge_sync.sv
module sg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("sg_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sg_divider.sv
module sg_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] div_new_i,
   output logic [DIV_W-1:0] div_act_o,
   output logic             bnd_o,
   output logic             clkg_o,
   output logic             en_o
);
   localparam int LEN_W = DIV_W + 1;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;
   logic             en_q;
   logic [LEN_W-1:0] len;
   logic [LEN_W-1:0] hi_len;

   assign len    = LEN_W'(div_q) + LEN_W'(1);
   assign hi_len = len >> 1;
   assign bnd_o  = run_i & tick_i & (cnt_q == div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= DIV_W'(1);
         en_q  <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         div_q <= div_new_i;
         en_q  <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q == div_q) begin
            cnt_q <= '0;
            div_q <= div_new_i;
            en_q  <= 1'b1;
         end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            en_q  <= 1'b0;
         end
      end else begin
         en_q <= 1'b0;
      end
   end

   always_comb begin
      if (!run_i)
         clkg_o = 1'b0;
      else if (div_q == '0)
         clkg_o = en_q;
      else
         clkg_o = (LEN_W'(cnt_q) < hi_len);
   end

   assign en_o      = en_q & run_i;
   assign div_act_o = div_q;
endmodule

// File: rtl/sg_frame.sv
module sg_frame #(
   parameter int WID_W = 8,
   parameter int PER_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             bnd_i,
   input  logic [WID_W-1:0] wid_new_i,
   input  logic [PER_W-1:0] per_new_i,
   output logic [WID_W-1:0] wid_act_o,
   output logic [PER_W-1:0] per_act_o,
   output logic             fsg_o
);
   logic [PER_W-1:0] fcnt_q;
   logic [WID_W-1:0] wid_q;
   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] wid_ext;
   logic             sat;

   generate
      if (PER_W < WID_W) begin : g_bad
         $error("sg_frame: PER_W must not be narrower than WID_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         wid_q  <= '0;
         per_q  <= '0;
      end else if (!run_i) begin
         fcnt_q <= '0;
         wid_q  <= wid_new_i;
         per_q  <= per_new_i;
      end else if (bnd_i) begin
         fcnt_q <= (fcnt_q >= per_q) ? '0 : fcnt_q + PER_W'(1);
         wid_q  <= wid_new_i;
         per_q  <= per_new_i;
      end
   end

   assign wid_ext   = PER_W'(wid_q);
   assign sat       = (wid_ext >= per_q);
   assign fsg_o     = run_i & (sat | (fcnt_q <= wid_ext));
   assign wid_act_o = wid_q;
   assign per_act_o = per_q;
endmodule

// File: rtl/sample_rate_gen.sv
module sample_rate_gen #(
   parameter int DIV_W       = 8,
   parameter int WID_W       = 8,
   parameter int PER_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [WID_W+DIV_W-1:0] cfg_wdata,
   output logic [WID_W+DIV_W-1:0] cfg_word,
   input  logic [1:0]             clk_src,
   input  logic [PER_W-1:0]       frm_period,
   input  logic                   periph_tick,
   input  logic                   rx_clk_pin,
   input  logic                   tx_clk_pin,
   output logic                   clkg,
   output logic                   clkg_en,
   output logic                   fsg
);
   import sg_pkg::*;

   localparam int CFG_W = WID_W + DIV_W;
   localparam int NPINS = 2;

   generate
      if (DIV_W < 1 || WID_W < 1) begin : g_bad_fields
         $error("sample_rate_gen: field widths must be positive");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic [NPINS-1:0] pin_raw;
   logic [NPINS-1:0] pin_rise;
   logic             run;
   logic             tick;
   logic             bnd;
   logic [DIV_W-1:0] div_act;
   logic [WID_W-1:0] wid_act;
   logic [PER_W-1:0] per_act;
   sg_src_e          src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= CFG_W'(1);
      else if (cfg_we)
         cfg_q <= cfg_wdata;
   end
   assign cfg_word = cfg_q;

   assign pin_raw = {tx_clk_pin, rx_clk_pin};

   generate
      for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
         sg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_raw[gi]),
            .rise_o (pin_rise[gi])
         );
      end
   endgenerate

   assign src = sg_src_e'(clk_src);
   assign run = (src != SRC_OFF);

   always_comb begin
      unique case (src)
         SRC_PER: tick = periph_tick;
         SRC_RXP: tick = pin_rise[0];
         SRC_TXP: tick = pin_rise[1];
         default: tick = 1'b0;
      endcase
   end

   sg_divider #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .tick_i    (tick),
      .div_new_i (cfg_q[DIV_W-1:0]),
      .div_act_o (div_act),
      .bnd_o     (bnd),
      .clkg_o    (clkg),
      .en_o      (clkg_en)
   );

   sg_frame #(.WID_W(WID_W), .PER_W(PER_W)) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .bnd_i     (bnd),
      .wid_new_i (cfg_q[CFG_W-1:DIV_W]),
      .per_new_i (frm_period),
      .wid_act_o (wid_act),
      .per_act_o (per_act),
      .fsg_o     (fsg)
   );
endmodule

// File: rtl/sample_rate_gen_chk.sv
module sample_rate_gen_chk #(
   parameter int DIV_W = 8,
   parameter int WID_W = 8,
   parameter int PER_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       clk_src,
   input logic             clkg,
   input logic             clkg_en,
   input logic             fsg,
   input logic [DIV_W-1:0] div_act,
   input logic [WID_W-1:0] wid_act,
   input logic [PER_W-1:0] per_act
);
   logic running;
   assign running = (clk_src != 2'b00);

   // R9
   reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!clkg && !clkg_en && !fsg));

   // R4
   unit_div_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && div_act == '0) |-> (clkg == clkg_en));

   // R4
   rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && div_act != '0 && $rose(clkg)) |-> clkg_en);

   // R10
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !clkg_en) |-> $stable(div_act));

   // R7
   width_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && PER_W'(wid_act) >= per_act) |-> fsg);
endmodule

bind sample_rate_gen sample_rate_gen_chk #(
   .DIV_W (DIV_W),
   .WID_W (WID_W),
   .PER_W (PER_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clk_src (clk_src),
   .clkg    (clkg),
   .clkg_en (clkg_en),
   .fsg     (fsg),
   .div_act (div_act),
   .wid_act (wid_act),
   .per_act (per_act)
);

// File: tb/sample_rate_gen_bench.sv
module sample_rate_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_word;
   logic [1:0]  clk_src = 2'b00;
   logic [11:0] frm_period = '0;
   logic        periph_tick = 1'b0;
   logic        rx_clk_pin = 1'b0;
   logic        tx_clk_pin = 1'b0;
   logic        clkg, clkg_en, fsg;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit mdl_on = 1'b0;

   // reference state
   int m_cnt, m_div, m_f, m_wid, m_per, m_en;
   logic [15:0] m_sh;

   always #10 clk = ~clk;

   sample_rate_gen u_sample_rate_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_word(cfg_word), .clk_src(clk_src), .frm_period(frm_period),
      .periph_tick(periph_tick), .rx_clk_pin(rx_clk_pin), .tx_clk_pin(tx_clk_pin),
      .clkg(clkg), .clkg_en(clkg_en), .fsg(fsg)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   function automatic int exp_clkg(input int run);
      if (run == 0) return 0;
      if (m_div == 0) return m_en;
      return (m_cnt < (m_div + 1) / 2) ? 1 : 0;
   endfunction

   function automatic int exp_fsg(input int run);
      if (run == 0) return 0;
      return (m_wid >= m_per || m_f <= m_wid) ? 1 : 0;
   endfunction

   task automatic mdl_reset();
      m_sh = 16'h0001; m_div = 1; m_wid = 0; m_per = 0;
      m_cnt = 0; m_f = 0; m_en = 0;
   endtask

   task automatic step(input logic [1:0] s, input logic t, input logic we,
                       input logic [15:0] wd, input logic [11:0] p);
      int run_now;
      @(negedge clk);
      run_now = (clk_src != 2'b00) ? 1 : 0;
      if (mdl_on) begin
         check("R4 clkg", int'(clkg), exp_clkg(run_now));
         check("R3/R10 clkg_en", int'(clkg_en), run_now != 0 ? m_en : 0);
         check("R5/R6 fsg", int'(fsg), exp_fsg(run_now));
         check("R1 cfg_word", int'(cfg_word), int'(m_sh));
      end
      clk_src = s; periph_tick = t; cfg_we = we; cfg_wdata = wd; frm_period = p;
      if (s == 2'b00) begin
         m_cnt = 0; m_f = 0; m_en = 0;
         m_div = m_sh[7:0]; m_wid = m_sh[15:8]; m_per = p;
      end else if (t) begin
         if (m_cnt == m_div) begin
            m_cnt = 0;
            m_f = (m_f >= m_per) ? 0 : m_f + 1;
            m_div = m_sh[7:0]; m_wid = m_sh[15:8]; m_per = p;
            m_en = 1;
         end else begin
            m_cnt++; m_en = 0;
         end
      end else begin
         m_en = 0;
      end
      if (we) m_sh = wd;
   endtask

   // pin toggling with strobe counting, inputs driven at negedge
   task automatic pin_edges(input int which, input int n, input bit distract, ref int cnt);
      for (int e = 0; e < n; e++) begin
         for (int ph = 0; ph < 6; ph++) begin
            @(negedge clk);
            if (clkg_en) cnt++;
            if (which == 0) rx_clk_pin = (ph < 3);
            else            tx_clk_pin = (ph < 3);
            if (distract) begin
               if (which == 0) tx_clk_pin = ph[0];
               else            rx_clk_pin = ph[0];
            end
         end
      end
      rx_clk_pin = 1'b0; tx_clk_pin = 1'b0;
      for (int w = 0; w < 8; w++) begin
         @(negedge clk);
         if (clkg_en) cnt++;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int cnt;
      int all_hi;
      logic [11:0] per_r;
      void'($urandom(32'd4242));
      mdl_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state of the control word and strobe
      check("R2 cfg_word reset", int'(cfg_word), 16'h0001);
      check("R2 clkg_en reset", int'(clkg_en), 0);
      mdl_on = 1'b1;

      // R9: reserved code keeps outputs low
      for (int i = 0; i < 6; i++) step(2'b00, 1'b1, 1'b0, '0, 12'd3);

      // R3/R4 default divide by two, continuous ticks
      for (int i = 0; i < 20; i++) step(2'b01, 1'b1, 1'b0, '0, 12'd3);

      // R4: D=0 unit divide, W=1, P=4 (R5, R6)
      step(2'b01, 1'b1, 1'b1, {8'd1, 8'd0}, 12'd4);
      for (int i = 0; i < 40; i++) step(2'b01, 1'b1, 1'b0, '0, 12'd4);

      // R4: odd length D=2, sparse ticks; R10 write mid-period
      step(2'b01, 1'b0, 1'b1, {8'd0, 8'd2}, 12'd2);
      for (int i = 0; i < 30; i++) step(2'b01, i[0], 1'b0, '0, 12'd2);
      step(2'b01, 1'b1, 1'b1, {8'd2, 8'd4}, 12'd5);
      for (int i = 0; i < 60; i++) step(2'b01, 1'b1, 1'b0, '0, 12'd5);

      // R7: width at or above period keeps fsg high
      step(2'b01, 1'b1, 1'b1, {8'd5, 8'd1}, 12'd3);
      for (int i = 0; i < 6; i++) step(2'b01, 1'b1, 1'b0, '0, 12'd3);
      all_hi = 1;
      for (int i = 0; i < 40; i++) begin
         step(2'b01, 1'b1, 1'b0, '0, 12'd3);
         if (!fsg) all_hi = 0;
      end
      check("R7 fsg held high", all_hi, 1);

      // R9: stop, then restart from position zero
      for (int i = 0; i < 5; i++) step(2'b00, 1'b1, 1'b0, '0, 12'd3);
      check("R9 clkg low", int'(clkg), 0);
      check("R9 fsg low", int'(fsg), 0);
      for (int i = 0; i < 10; i++) step(2'b01, 1'b1, 1'b0, '0, 12'd3);

      // random mix on the peripheral tick
      per_r = 12'd6;
      for (int i = 0; i < 4000; i++) begin
         logic t, we;
         logic [15:0] wd;
         t  = ($urandom % 3) != 0;
         we = ($urandom % 40) == 0;
         wd = {8'($urandom % 8), 8'($urandom % 6)};
         if (($urandom % 60) == 0) per_r = 12'($urandom % 10);
         step(2'b01, t, we, wd, per_r);
      end

      // R8: pin sources, model off
      step(2'b00, 1'b0, 1'b1, {8'd0, 8'd2}, 12'd3);
      step(2'b00, 1'b0, 1'b0, '0, 12'd3);
      mdl_on = 1'b0;
      @(negedge clk);
      clk_src = 2'b10;
      cnt = 0;
      pin_edges(0, 12, 1'b1, cnt);
      check("R8 rx pin strobes", cnt, 4);

      @(negedge clk); clk_src = 2'b00;
      @(negedge clk); clk_src = 2'b11;
      cnt = 0;
      pin_edges(0, 9, 1'b0, cnt);
      check("R8 rx ignored under tx select", cnt, 0);
      cnt = 0;
      pin_edges(1, 9, 1'b1, cnt);
      check("R8 tx pin strobes", cnt, 3);

      @(negedge clk); clk_src = 2'b00;
      @(negedge clk);
      cnt = 0;
      pin_edges(0, 4, 1'b1, cnt);
      check("R9 no strobes when reserved", cnt, 0);

      // back to the model for a final periph stretch
      step(2'b00, 1'b0, 1'b0, '0, 12'd3);
      mdl_on = 1'b1;
      for (int i = 0; i < 50; i++) step(2'b01, 1'b1, 1'b0, '0, 12'd3);

      finish_run();
   end
endmodule